// File: doc/BRIEF.md
# Debug Transport Test Access Port

This block is a serial test access port that exposes a small debug-transport register bank. It is clocked by the test clock and steered by the mode-select line. A sixteen-state controller walks the capture, shift, pause and update phases for both the instruction path and the data path. A 5-bit instruction chooses one of four data registers: a one-bit bypass, a 32-bit identification word, a 32-bit transport status word, and a 41-bit debug-access register.

The debug-access register connects to the debug logic behind it through a plain side interface. On capture it loads a 41-bit word that the debug side presents. On update it hands back the 41 bits that were scanned in, together with a one-cycle strobe. A downstream active-low debug reset is held while the controller sits in Test-Logic-Reset or when the test reset line is raised. That reset is released once the controller runs in Run-Test/Idle.

Top module: `dbg_tap`

## Requirements
- R1: While `rst_n` is low at a rising `tck` edge, the controller is forced to Test-Logic-Reset, the instruction becomes 0x01, and `dbg_rst_n` and `acc_upd` are low. `tdo` is low after the following falling edge.
- R2: At each rising `tck` edge the controller follows the standard sixteen-state transitions on `tms`. Five edges with `tms` high reach Test-Logic-Reset from any state, and it remains there while `tms` stays high.
- R3: At a rising edge taken in Test-Logic-Reset, the instruction becomes 0x01 (identification) and `dbg_rst_n` goes low. At a rising edge taken in Run-Test/Idle without `trst`, `dbg_rst_n` goes high.
- R4: Capture-IR loads the instruction shift register with 0b00101. Shift-IR moves it right by one, with `tdi` entering bit 4. Update-IR copies it into the current instruction.
- R5: Instruction decode is 0x00 and 0x1F to bypass, 0x01 to identification, 0x10 to transport status, and 0x11 to debug access. Every other code selects bypass.
- R6: The identification register captures the 32-bit constant 0x04F5484D.
- R7: The transport status register captures 0x00000071. Bits [3:0] hold version 1, bits [9:4] hold the address width 7, and all other bits are zero, which includes the idle-cycle hint and the status field.
- R8: The bypass register is one bit and captures 0, so a bit scanned in appears on `tdo` one shift later.
- R9: Data shifting is LSB first. On each Shift-DR edge the selected register moves right by one, and `tdi` enters at bit (length-1) of that register, which is 32 for identification and status and 41 for debug access.
- R10: `tdo` changes only on falling `tck` edges. It shows bit 0 of the data shift register while in Shift-DR, and bit 0 of the instruction shift register in every other state.
- R11: The debug-access register captures `acc_cap_word`, laid out as address [40:34], data [33:2] and op [1:0]. An Update-DR under instruction 0x11 raises `acc_upd` for exactly one cycle, with `acc_upd_word` equal to the 41 bits scanned in. Update-DR under any other instruction gives no strobe.
- R12: `trst` high at a rising edge forces Run-Test/Idle and drives `dbg_rst_n` low. It leaves the current instruction unchanged.
- R13: Leaving Shift-DR through Exit1, Pause and Exit2, and then returning to Shift-DR, resumes the scan with no new capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock; all controller state moves on its rising edge |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| trst | input | 1 | Synchronous test reset request, active high |
| tms | input | 1 | Mode select steering the controller |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| dbg_rst_n | output | 1 | Active-low reset for the downstream debug logic |
| acc_cap_word | input | 41 | Word loaded into the debug-access register on capture |
| acc_upd | output | 1 | One-cycle strobe after a debug-access update |
| acc_upd_word | output | 41 | Debug-access value handed over with the strobe |

## Verification
The properties assume that `tms`, `tdi`, `trst` and `rst_n` are stable around each rising `tck` edge. They also assume that both reset inputs act only as synchronous requests. The stimulus changes every input one nanosecond after a falling edge and samples `tdo` just after that edge, so each value is settled for half a period before the rising edge that consumes it. `trst` is raised for a single edge in the middle of a data scan. `rst_n` is held low for several edges at the start, so the properties are never judged against values from before reset.

// File: rtl/dbg_tap_pkg.sv
// Package: shared types and constants for the debug transport TAP.
// Assumes a 5-bit instruction register with a fixed code assignment.
package dbg_tap_pkg;

    localparam int IR_W = 5;

    // Controller states
    typedef enum logic [3:0] {
        TS_RESET,
        TS_IDLE,
        TS_SEL_DR,
        TS_CAP_DR,
        TS_SH_DR,
        TS_EX1_DR,
        TS_PAU_DR,
        TS_EX2_DR,
        TS_UPD_DR,
        TS_SEL_IR,
        TS_CAP_IR,
        TS_SH_IR,
        TS_EX1_IR,
        TS_PAU_IR,
        TS_EX2_IR,
        TS_UPD_IR
    } tap_st_e;

    // Data register selection
    typedef enum logic [1:0] {
        DSEL_BYP,
        DSEL_ID,
        DSEL_STAT,
        DSEL_ACC
    } dsel_e;

    localparam logic [IR_W-1:0] INS_BYP_LO = 5'h00;
    localparam logic [IR_W-1:0] INS_IDCODE = 5'h01;
    localparam logic [IR_W-1:0] INS_STAT   = 5'h10;
    localparam logic [IR_W-1:0] INS_ACC    = 5'h11;
    localparam logic [IR_W-1:0] INS_BYP_HI = 5'h1F;
    localparam logic [IR_W-1:0] IR_CAPTURE = 5'b00101;

    // Next-state function of the sixteen-state controller
    function automatic tap_st_e tap_next(input tap_st_e s, input logic m);
        tap_st_e n;
        case (s)
            TS_RESET:  n = m ? TS_RESET  : TS_IDLE;
            TS_IDLE:   n = m ? TS_SEL_DR : TS_IDLE;
            TS_SEL_DR: n = m ? TS_SEL_IR : TS_CAP_DR;
            TS_CAP_DR: n = m ? TS_EX1_DR : TS_SH_DR;
            TS_SH_DR:  n = m ? TS_EX1_DR : TS_SH_DR;
            TS_EX1_DR: n = m ? TS_UPD_DR : TS_PAU_DR;
            TS_PAU_DR: n = m ? TS_EX2_DR : TS_PAU_DR;
            TS_EX2_DR: n = m ? TS_UPD_DR : TS_SH_DR;
            TS_UPD_DR: n = m ? TS_SEL_DR : TS_IDLE;
            TS_SEL_IR: n = m ? TS_RESET  : TS_CAP_IR;
            TS_CAP_IR: n = m ? TS_EX1_IR : TS_SH_IR;
            TS_SH_IR:  n = m ? TS_EX1_IR : TS_SH_IR;
            TS_EX1_IR: n = m ? TS_UPD_IR : TS_PAU_IR;
            TS_PAU_IR: n = m ? TS_EX2_IR : TS_PAU_IR;
            TS_EX2_IR: n = m ? TS_UPD_IR : TS_SH_IR;
            TS_UPD_IR: n = m ? TS_SEL_DR : TS_IDLE;
            default:   n = TS_RESET;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/dbg_tap_fsm.sv
// Module: TAP controller state register and downstream debug reset.
// Assumes rst_n and trst are synchronous to the rising edge of tck.
// trst forces Run-Test/Idle and asserts the debug reset; the reset is
// driven low by an edge taken in Test-Logic-Reset and released by an
// edge taken in Run-Test/Idle.
module dbg_tap_fsm
    import dbg_tap_pkg::*;
(
    input  logic    tck,
    input  logic    rst_n,
    input  logic    trst,
    input  logic    tms,
    output tap_st_e state,
    output logic    dbg_rst_n
);

    tap_st_e st_q;
    logic    drst_q;

    // Advance the controller on every rising test clock edge
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            st_q <= TS_RESET;
        end else if (trst) begin
            st_q <= TS_IDLE;
        end else begin
            st_q <= tap_next(st_q, tms);
        end
    end

    // Hold or release the downstream debug reset according to the state
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            drst_q <= 1'b0;
        end else if (trst) begin
            drst_q <= 1'b0;
        end else if (st_q == TS_RESET) begin
            drst_q <= 1'b0;
        end else if (st_q == TS_IDLE) begin
            drst_q <= 1'b1;
        end
    end

    assign state     = st_q;
    assign dbg_rst_n = drst_q;

endmodule

// File: rtl/dbg_tap_ir.sv
// Module: instruction shift register, current instruction and decode.
// Assumes the controller state is registered on the same rising edge.
// Codes that are not assigned decode to bypass.
module dbg_tap_ir
    import dbg_tap_pkg::*;
(
    input  logic            tck,
    input  logic            rst_n,
    input  tap_st_e         state,
    input  logic            tdi,
    output logic [IR_W-1:0] ir_sr,
    output logic [IR_W-1:0] ir_cur,
    output dsel_e           sel
);

    logic [IR_W-1:0] sr_q;
    logic [IR_W-1:0] cur_q;

    // Capture the fixed pattern, then shift LSB first with tdi at the top
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (state == TS_CAP_IR) begin
            sr_q <= IR_CAPTURE;
        end else if (state == TS_SH_IR) begin
            sr_q <= {tdi, sr_q[IR_W-1:1]};
        end
    end

    // Load the current instruction on update; fall back to IDCODE in reset
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            cur_q <= INS_IDCODE;
        end else if (state == TS_RESET) begin
            cur_q <= INS_IDCODE;
        end else if (state == TS_UPD_IR) begin
            cur_q <= sr_q;
        end
    end

    // Map the instruction code onto a data register choice
    always_comb begin
        case (cur_q)
            INS_IDCODE: sel = DSEL_ID;
            INS_STAT:   sel = DSEL_STAT;
            INS_ACC:    sel = DSEL_ACC;
            INS_BYP_LO: sel = DSEL_BYP;
            INS_BYP_HI: sel = DSEL_BYP;
            default:    sel = DSEL_BYP;
        endcase
    end

    assign ir_sr  = sr_q;
    assign ir_cur = cur_q;

endmodule

// File: rtl/dbg_tap_dr.sv
// Module: shared data shift register for all four data registers.
// One register of the widest length serves every instruction; the
// selected length only moves the tdi insertion point. The access
// update is registered and appears one cycle after the Update-DR edge.
// Assumes the selection is stable from Capture-DR through Update-DR.
module dbg_tap_dr
    import dbg_tap_pkg::*;
#(
    parameter int          ACC_W    = 41,
    parameter int          WORD_W   = 32,
    parameter logic [31:0] ID_VAL   = 32'h04F5484D,
    parameter logic [31:0] STAT_VAL = 32'h00000071
) (
    input  logic             tck,
    input  logic             rst_n,
    input  tap_st_e          state,
    input  dsel_e            sel,
    input  logic             tdi,
    input  logic [ACC_W-1:0] cap_word,
    output logic             dr_lsb,
    output logic             upd,
    output logic [ACC_W-1:0] upd_word
);

    localparam int DR_W = (ACC_W > WORD_W) ? ACC_W : WORD_W;
    localparam int LW   = $clog2(DR_W);
    localparam logic [LW-1:0] LEN_BYP  = '0;
    localparam logic [LW-1:0] LEN_WORD = LW'(WORD_W - 1);
    localparam logic [LW-1:0] LEN_ACC  = LW'(ACC_W - 1);

    logic [DR_W-1:0]  sr_q;
    logic [DR_W-1:0]  sh_next;
    logic [DR_W-1:0]  cap_val;
    logic [LW-1:0]    top_idx;
    logic             upd_q;
    logic [ACC_W-1:0] upd_word_q;

    // Pick the top bit position and the capture value for the selection
    always_comb begin
        case (sel)
            DSEL_ID: begin
                top_idx = LEN_WORD;
                cap_val = DR_W'(ID_VAL);
            end
            DSEL_STAT: begin
                top_idx = LEN_WORD;
                cap_val = DR_W'(STAT_VAL);
            end
            DSEL_ACC: begin
                top_idx = LEN_ACC;
                cap_val = DR_W'(cap_word);
            end
            default: begin
                top_idx = LEN_BYP;
                cap_val = '0;
            end
        endcase
    end

    // Per-bit shift path: tdi lands on the selected top bit
    for (genvar g = 0; g < DR_W; g++) begin : g_sh
        if (g == DR_W - 1) begin : g_top
            assign sh_next[g] = (top_idx == LW'(g)) ? tdi : 1'b0;
        end else begin : g_mid
            assign sh_next[g] = (top_idx == LW'(g)) ? tdi : sr_q[g+1];
        end
    end

    // Capture or shift the data register
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (state == TS_CAP_DR) begin
            sr_q <= cap_val;
        end else if (state == TS_SH_DR) begin
            sr_q <= sh_next;
        end
    end

    // Hand the access value to the debug side with a one-cycle strobe
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            upd_q      <= 1'b0;
            upd_word_q <= '0;
        end else begin
            upd_q <= (state == TS_UPD_DR) && (sel == DSEL_ACC);
            if ((state == TS_UPD_DR) && (sel == DSEL_ACC)) begin
                upd_word_q <= sr_q[ACC_W-1:0];
            end
        end
    end

    assign dr_lsb   = sr_q[0];
    assign upd      = upd_q;
    assign upd_word = upd_word_q;

endmodule

// File: rtl/dbg_tap_tdo.sv
// Module: serial output stage, retimed to the falling edge of tck.
// Assumes the state seen at the falling edge is the one just entered.
module dbg_tap_tdo
    import dbg_tap_pkg::*;
(
    input  logic    tck,
    input  logic    rst_n,
    input  tap_st_e state,
    input  logic    dr_lsb,
    input  logic    ir_lsb,
    output logic    tdo
);

    logic tdo_q;

    // Present the data LSB in Shift-DR, else the instruction LSB
    always_ff @(negedge tck) begin
        if (!rst_n) begin
            tdo_q <= 1'b0;
        end else begin
            tdo_q <= (state == TS_SH_DR) ? dr_lsb : ir_lsb;
        end
    end

    assign tdo = tdo_q;

endmodule

// File: rtl/dbg_tap.sv
// Module: debug transport TAP top. It joins the controller, the
// instruction path, the data register bank and the output stage.
// The status word is built from the address width, version and idle hint.
// Assumes all control inputs are synchronous to tck.
module dbg_tap
    import dbg_tap_pkg::*;
#(
    parameter int          ADDR_W    = 7,
    parameter int          DATA_W    = 32,
    parameter int          OP_W      = 2,
    parameter logic [31:0] IDCODE    = 32'h04F5484D,
    parameter logic [3:0]  VERSION   = 4'd1,
    parameter logic [2:0]  IDLE_HINT = 3'd0,
    localparam int         ACC_W     = ADDR_W + DATA_W + OP_W
) (
    input  logic             tck,
    input  logic             rst_n,
    input  logic             trst,
    input  logic             tms,
    input  logic             tdi,
    output logic             tdo,
    output logic             dbg_rst_n,
    input  logic [ACC_W-1:0] acc_cap_word,
    output logic             acc_upd,
    output logic [ACC_W-1:0] acc_upd_word
);

    localparam logic [31:0] STAT_WORD =
        {14'b0, 2'b00, 1'b0, IDLE_HINT, 2'b00, 6'(ADDR_W), VERSION};

    tap_st_e         st;
    logic [IR_W-1:0] ir_sr;
    logic [IR_W-1:0] ir_cur;
    dsel_e           sel;
    logic            dr_lsb;

    dbg_tap_fsm u_fsm (
        .tck       (tck),
        .rst_n     (rst_n),
        .trst      (trst),
        .tms       (tms),
        .state     (st),
        .dbg_rst_n (dbg_rst_n)
    );

    dbg_tap_ir u_ir (
        .tck    (tck),
        .rst_n  (rst_n),
        .state  (st),
        .tdi    (tdi),
        .ir_sr  (ir_sr),
        .ir_cur (ir_cur),
        .sel    (sel)
    );

    dbg_tap_dr #(
        .ACC_W    (ACC_W),
        .WORD_W   (32),
        .ID_VAL   (IDCODE),
        .STAT_VAL (STAT_WORD)
    ) u_dr (
        .tck      (tck),
        .rst_n    (rst_n),
        .state    (st),
        .sel      (sel),
        .tdi      (tdi),
        .cap_word (acc_cap_word),
        .dr_lsb   (dr_lsb),
        .upd      (acc_upd),
        .upd_word (acc_upd_word)
    );

    dbg_tap_tdo u_tdo (
        .tck    (tck),
        .rst_n  (rst_n),
        .state  (st),
        .dr_lsb (dr_lsb),
        .ir_lsb (ir_sr[0]),
        .tdo    (tdo)
    );

endmodule

// File: rtl/dbg_tap_chk.sv
// Module: property checker for the debug transport TAP, bound to the top.
// Assumes synchronous resets and inputs stable at the rising edge.
module dbg_tap_chk
    import dbg_tap_pkg::*;
(
    input logic            tck,
    input logic            rst_n,
    input logic            trst,
    input logic            tms,
    input tap_st_e         state,
    input logic [IR_W-1:0] ir,
    input logic [IR_W-1:0] ir_sr,
    input logic            dbg_rst_n,
    input logic            acc_upd
);

    // R11: the update strobe never lasts two cycles
    a_r11_upd_pulse: assert property (@(posedge tck) disable iff (!rst_n)
        acc_upd |=> !acc_upd);

    // R11: a strobe only follows an update under the access instruction
    a_r11_upd_only_acc: assert property (@(posedge tck) disable iff (!rst_n)
        acc_upd |-> (ir == INS_ACC));

    // R12: test reset lands in Run-Test/Idle with the debug reset held
    a_r12_trst_idle: assert property (@(posedge tck) disable iff (!rst_n)
        trst |=> (state == TS_IDLE) && !dbg_rst_n);

    // R3: an edge in Test-Logic-Reset selects IDCODE and holds debug reset
    a_r3_tlr_effect: assert property (@(posedge tck) disable iff (!rst_n)
        (state == TS_RESET) |=> !dbg_rst_n && (ir == INS_IDCODE));

    // R3: an edge in Run-Test/Idle releases the debug reset
    a_r3_idle_release: assert property (@(posedge tck) disable iff (!rst_n)
        (state == TS_IDLE) && !trst |=> dbg_rst_n);

    // R4: Capture-IR loads the fixed pattern
    a_r4_capir: assert property (@(posedge tck) disable iff (!rst_n)
        (state == TS_CAP_IR) |=> (ir_sr == IR_CAPTURE));

    // R2: Test-Logic-Reset is held while tms stays high
    a_r2_tlr_hold: assert property (@(posedge tck) disable iff (!rst_n)
        (state == TS_RESET) && tms && !trst |=> (state == TS_RESET));

endmodule

bind dbg_tap dbg_tap_chk u_chk (
    .tck       (tck),
    .rst_n     (rst_n),
    .trst      (trst),
    .tms       (tms),
    .state     (st),
    .ir        (ir_cur),
    .ir_sr     (ir_sr),
    .dbg_rst_n (dbg_rst_n),
    .acc_upd   (acc_upd)
);

// File: tb/dbg_tap_bench.sv
// Bench: walks a table of instruction/expected-capture vectors, then
// runs directed tests for reset, length, bypass delay, pause and trst.
module dbg_tap_bench;

    localparam logic [40:0] CAPW = 41'h123456789AB;
    localparam logic [40:0] DIN  = 41'h15A5A5A5A5A;

    typedef struct packed {
        logic [4:0]  ins;
        logic [5:0]  len;
        logic [40:0] exp;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{5'h00, 6'd1,  41'h0},
        '{5'h1F, 6'd1,  41'h0},
        '{5'h01, 6'd32, 41'h004F5484D},
        '{5'h10, 6'd32, 41'h000000071},
        '{5'h05, 6'd1,  41'h0},
        '{5'h11, 6'd41, CAPW},
        '{5'h1E, 6'd1,  41'h0}
    };

    logic        tck   = 1'b0;
    logic        rst_n = 1'b0;
    logic        trst  = 1'b0;
    logic        tms   = 1'b1;
    logic        tdi   = 1'b0;
    logic        tdo;
    logic        dbg_rst_n;
    logic        acc_upd;
    logic [40:0] acc_upd_word;
    logic [40:0] acc_cap_word = CAPW;

    int   total = 0;
    int   bad   = 0;
    bit   done  = 1'b0;
    logic tdo_s, upd_s, rstn_s;

    always #10 tck = ~tck;

    dbg_tap u_dbg_tap (
        .tck          (tck),
        .rst_n        (rst_n),
        .trst         (trst),
        .tms          (tms),
        .tdi          (tdi),
        .tdo          (tdo),
        .dbg_rst_n    (dbg_rst_n),
        .acc_cap_word (acc_cap_word),
        .acc_upd      (acc_upd),
        .acc_upd_word (acc_upd_word)
    );

    task automatic check(input string req, input logic [40:0] act, input logic [40:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One test clock: drive, pass a rising and falling edge, then sample
    task automatic tick(input logic m, input logic d);
        tms = m;
        tdi = d;
        @(posedge tck);
        @(negedge tck);
        #1;
        tdo_s  = tdo;
        upd_s  = acc_upd;
        rstn_s = dbg_rst_n;
    endtask

    // From Run-Test/Idle: load an instruction, return what was captured
    task automatic scan_ir(input logic [4:0] ins, output logic [4:0] cap);
        tick(1'b1, 1'b0);
        tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b0);
        for (int i = 0; i < 5; i++) begin
            cap[i] = tdo_s;
            tick(i == 4, ins[i]);
        end
        tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
    endtask

    // From Run-Test/Idle: scan len bits of din, return the bits seen
    task automatic scan_dr(input int len, input logic [40:0] din, output logic [40:0] dout);
        dout = '0;
        tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b0);
        for (int i = 0; i < len; i++) begin
            dout[i] = tdo_s;
            tick(i == len - 1, din[i]);
        end
        tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
    endtask

    function automatic string tag_of(input logic [4:0] ins);
        case (ins)
            5'h11:        return "R11 access capture";
            5'h01:        return "R6 identification";
            5'h10:        return "R7 status word";
            5'h00, 5'h1F: return "R8 bypass";
            default:      return "R5 unknown code";
        endcase
    endfunction

    // Watchdog: a hang counts as a failure
    initial begin
        repeat (100000) @(posedge tck);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R2 watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [4:0]  cap;
        logic [40:0] dout;
        logic [40:0] mask;
        logic [7:0]  bp_in;

        // R1: reset state
        tick(1'b1, 1'b0);
        tick(1'b1, 1'b0);
        tick(1'b1, 1'b0);
        check("R1 debug reset low", 41'(rstn_s), 41'h0);
        check("R1 tdo low", 41'(tdo_s), 41'h0);
        check("R1 no strobe", 41'(upd_s), 41'h0);
        rst_n = 1'b1;
        tick(1'b0, 1'b0);
        check("R3 reset held by edge in TLR", 41'(rstn_s), 41'h0);
        tick(1'b0, 1'b0);
        check("R3 release in idle", 41'(rstn_s), 41'h1);
        scan_dr(32, DIN, dout);
        check("R1 default instruction reads id", dout & 41'hFFFFFFFF, 41'h004F5484D);

        // Vector table: R4 capture pattern, R5 decode, R6 R7 R8 R11 values
        for (int k = 0; k < 7; k++) begin
            scan_ir(VECS[k].ins, cap);
            check("R4 capture-IR pattern", 41'(cap), 41'h05);
            scan_dr(int'(VECS[k].len), DIN, dout);
            mask = {41{1'b1}} >> (41 - int'(VECS[k].len));
            check(tag_of(VECS[k].ins), dout & mask, VECS[k].exp);
            if (VECS[k].ins == 5'h11) begin
                check("R11 strobe after update", 41'(upd_s), 41'h1);
                check("R11 update word", acc_upd_word, DIN);
                tick(1'b0, 1'b0);
                check("R11 strobe one cycle", 41'(upd_s), 41'h0);
            end else begin
                check("R11 no strobe off access", 41'(upd_s), 41'h0);
            end
        end

        // R9: tdi enters at bit 31 of the identification register
        scan_ir(5'h01, cap);
        scan_dr(41, DIN, dout);
        check("R9 insertion at length", dout, {DIN[8:0], 32'h04F5484D});

        // R8: bypass delays the stream by one shift
        scan_ir(5'h1F, cap);
        bp_in = 8'b1011_0010;
        scan_dr(8, 41'(bp_in), dout);
        check("R8 one-bit delay", dout & 41'hFF, 41'({bp_in[6:0], 1'b0}));

        // R13 and R10: pause in the middle of an access scan
        scan_ir(5'h11, cap);
        dout = '0;
        tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b0);
        for (int i = 0; i < 4; i++) begin
            dout[i] = tdo_s;
            tick(i == 3, DIN[i]);
        end
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b0);
        check("R10 tdo shows IR LSB in pause", 41'(tdo_s), 41'h1);
        tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
        for (int i = 4; i < 41; i++) begin
            dout[i] = tdo_s;
            tick(i == 40, DIN[i]);
        end
        tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
        check("R13 read across pause", dout, CAPW);
        check("R13 update across pause", acc_upd_word, DIN);

        // R12: test reset in the middle of a status scan
        scan_ir(5'h10, cap);
        tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b1);
        tick(1'b0, 1'b1);
        trst = 1'b1;
        tick(1'b1, 1'b0);
        trst = 1'b0;
        check("R12 debug reset on trst", 41'(rstn_s), 41'h0);
        tick(1'b0, 1'b0);
        check("R12 lands in idle", 41'(rstn_s), 41'h1);
        scan_dr(32, DIN, dout);
        check("R12 instruction kept", dout & 41'hFFFFFFFF, 41'h000000071);

        // R2: five tms-high edges from Shift-DR reach Test-Logic-Reset
        scan_ir(5'h10, cap);
        tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b0);
        for (int i = 0; i < 5; i++) tick(1'b1, 1'b0);
        check("R2 not yet reset on entry", 41'(rstn_s), 41'h1);
        tick(1'b1, 1'b0);
        check("R2 in TLR after five edges", 41'(rstn_s), 41'h0);
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b0);
        check("R3 released after TLR", 41'(rstn_s), 41'h1);
        scan_dr(32, DIN, dout);
        check("R3 TLR selects id", dout & 41'hFFFFFFFF, 41'h004F5484D);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule